// File: doc/BRIEF.md
# Register-Mapped PWM Generator

A single-channel pulse-width modulator programmed through two 32-bit words on a minimal write/read port. A control word chooses a clock divider, the output polarity, a continuous or one-shot operating style, a software start for the one-shot, and a path that sends the input clock straight to the pin. A second word packs the period length and the number of active counts.

Each period lasts a programmed number of prescaled counts. During the first counts of a period, up to the programmed active count, the pin is at its active level; for the rest of the period it is at the opposite level. A new period word does not disturb the period in progress. It is held in a shadow copy and moved into the working registers when that period ends. Until the move happens, a read-only busy bit stays set. When the counter is not running, the move takes place on the next clock.

The counter runs only while both the enable bit and the gate bit are set. While it is stopped, the pin is held low, whatever the polarity.

Top module: `pwm_unit`

## Requirements
- R1: After reset every register bit is 0: both words read back as 0 and `pwm_out` is low.
- R2: The control word sits at byte offset 0x0. Bits [3:0] are the prescaler code, bit 4 is enable, bit 5 selects an active-high output, bit 6 is the gate, bit 7 selects one-shot mode (0 = continuous), bit 8 is start, bit 9 is clock bypass, and bit 28 is the read-only busy flag. The period word sits at offset 0x4, with bits [31:16] holding the period length minus one and bits [15:0] the active count. Both words read back the values written to them.
- R3: The counter runs only while both enable and gate are 1. Otherwise, with bypass clear, `pwm_out` is 0.
- R4: In continuous mode the pin is active during count k of every period while k < active, and each period has (length field + 1) counts.
- R5: Each count lasts D input clocks. Code 0xF gives D = 1; codes 0 to 5 give 120, 180, 240, 360, 480 and 12; codes 8 to 11 give 24000, 36000, 48000 and 72000.
- R6: Any other prescaler code freezes the counter, so the pin stays at the level of count 0.
- R7: With bit 5 set the active level is 1; with bit 5 clear the active level is 0 and the inactive level is 1.
- R8: A write to the period word sets busy on the next clock. The new values take effect at the next period boundary, when busy clears, or one clock later if the counter is stopped.
- R9: In one-shot mode, setting start produces exactly one period. At its end start clears itself and the pin goes to the inactive level. Writing start again retriggers.
- R10: An active count greater than the length field keeps the pin active for the whole period. An active count of 0 keeps it inactive.
- R11: With bypass set, `pwm_out` equals the input clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W | Byte address of the word (0x0 or 0x4) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed word, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest case to reach from the ports is a period word written while the counter runs. The reload then has to wait for a boundary whose phase the bench does not track. The stimulus starts a long period, writes a short one partway through, and polls the busy bit each cycle. The first cycle in which busy reads 0 must be count 0 of the new period, so the bench queues the new waveform from that cycle on. It also checks that busy stayed high for more than one cycle.

// File: rtl/pwm_unit_pkg.sv
package pwm_unit_pkg;

  localparam int CTRL_W   = 10;
  localparam int BUSY_BIT = 28;
  localparam int DIV_W    = 17;

  typedef struct packed {
    logic       bypass;
    logic       start;
    logic       pulse_mode;
    logic       gate;
    logic       act_high;
    logic       enable;
    logic [3:0] presc;
  } ctrl_t;

  // Divide factor for a prescaler code; 0 marks a reserved code.
  function automatic logic [DIV_W-1:0] presc_div(input logic [3:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'h0:    d = DIV_W'(120);
      4'h1:    d = DIV_W'(180);
      4'h2:    d = DIV_W'(240);
      4'h3:    d = DIV_W'(360);
      4'h4:    d = DIV_W'(480);
      4'h5:    d = DIV_W'(12);
      4'h8:    d = DIV_W'(24000);
      4'h9:    d = DIV_W'(36000);
      4'hA:    d = DIV_W'(48000);
      4'hB:    d = DIV_W'(72000);
      4'hF:    d = DIV_W'(1);
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pwm_unit_regs.sv
module pwm_unit_regs
  import pwm_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              pulse_done,
  input  logic              reload_take,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] shadow,
  output logic              pending,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_PER  = ADDR_W'(4);

  logic sel_ctrl, sel_per, wr_ctrl, wr_per;

  assign sel_ctrl = (bus_addr == OFF_CTRL);
  assign sel_per  = (bus_addr == OFF_PER);
  assign wr_ctrl  = bus_wr && sel_ctrl;
  assign wr_per   = bus_wr && sel_per;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      shadow  <= '0;
      pending <= 1'b0;
    end else begin
      if (wr_ctrl)
        ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      else if (pulse_done)
        ctrl.start <= 1'b0;
      if (wr_per) begin
        shadow  <= bus_wdata;
        pending <= 1'b1;
      end else if (reload_take) begin
        pending <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[CTRL_W-1:0] = ctrl;
      bus_rdata[BUSY_BIT]   = pending;
    end else if (sel_per) begin
      bus_rdata = shadow;
    end
  end

  assert_busy_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_per |=> pending);

  assert_start_self_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_done && !wr_ctrl) |=> !ctrl.start);

endmodule

// File: rtl/pwm_unit_presc.sv
module pwm_unit_presc
  import pwm_unit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       count_en,
  input  logic [3:0] code,
  output logic       tick
);

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] pc;
  logic             reserved;

  assign div      = presc_div(code);
  assign reserved = (div == '0);
  assign tick     = count_en && !reserved && (pc >= div - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pc <= '0;
    else if (!count_en || reserved || tick)
      pc <= '0;
    else
      pc <= pc + 1'b1;
  end

endmodule

// File: rtl/pwm_unit_counter.sv
module pwm_unit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic             tick,
  input  logic             pending,
  input  logic [CNT_W-1:0] shadow_tot,
  input  logic [CNT_W-1:0] shadow_act,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] work_tot,
  output logic [CNT_W-1:0] work_act,
  output logic             boundary,
  output logic             reload_take,
  output logic             in_active
);

  assign boundary    = tick && (cnt == work_tot);
  assign reload_take = pending && (boundary || !count_en);
  assign in_active   = count_en && (cnt < work_act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      work_tot <= '0;
      work_act <= '0;
    end else begin
      if (!count_en)
        cnt <= '0;
      else if (tick)
        cnt <= boundary ? '0 : cnt + 1'b1;
      if (reload_take) begin
        work_tot <= shadow_tot;
        work_act <= shadow_act;
      end
    end
  end

  assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    count_en |-> (cnt <= work_tot));

endmodule

// File: rtl/pwm_unit.sv
module pwm_unit
  import pwm_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);

  localparam int CNT_W = DATA_W / 2;

  ctrl_t             ctrl;
  logic [DATA_W-1:0] shadow;
  logic              pending;
  logic              run, count_en, tick;
  logic [CNT_W-1:0]  cnt, work_tot, work_act;
  logic              boundary, reload_take, in_active, pulse_done;
  logic              code_reserved;

  assign run        = ctrl.enable && ctrl.gate;
  assign count_en   = run && (!ctrl.pulse_mode || ctrl.start);
  assign pulse_done = count_en && ctrl.pulse_mode && boundary;
  assign code_reserved = (presc_div(ctrl.presc) == '0);

  pwm_unit_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pulse_done(pulse_done), .reload_take(reload_take),
    .ctrl(ctrl), .shadow(shadow), .pending(pending), .bus_rdata(bus_rdata)
  );

  pwm_unit_presc u_presc (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .code(ctrl.presc),
    .tick(tick)
  );

  pwm_unit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .count_en(count_en), .tick(tick),
    .pending(pending), .shadow_tot(shadow[DATA_W-1:CNT_W]),
    .shadow_act(shadow[CNT_W-1:0]), .cnt(cnt), .work_tot(work_tot),
    .work_act(work_act), .boundary(boundary), .reload_take(reload_take),
    .in_active(in_active)
  );

  always_comb begin
    if (ctrl.bypass)
      pwm_out = clk;
    else if (!run)
      pwm_out = 1'b0;
    else
      pwm_out = in_active ? ctrl.act_high : !ctrl.act_high;
  end

  assert_stopped_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctrl.bypass) |-> !pwm_out);

  assert_full_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !ctrl.bypass && (work_act > work_tot)) |-> (pwm_out == ctrl.act_high));

  assert_zero_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ctrl.bypass && (work_act == '0)) |-> (pwm_out == !ctrl.act_high));

  assert_reserved_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && code_reserved && $past(count_en && code_reserved)) |-> $stable(cnt));

endmodule

// File: tb/pwm_unit_bench.sv
module pwm_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int compared = 0;
  int mismatched = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  pwm_unit u_pwm_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic int bench_div(input int code);
    if (code == 15) return 1;
    if (code == 5)  return 12;
    if (code >= 0 && code <= 4) return (code == 0) ? 120 : (code == 1) ? 180 :
                                       (code == 2) ? 240 : (code == 3) ? 360 : 480;
    if (code >= 8 && code <= 11) return 24000 + 12000 * (code - 8) + ((code == 11) ? 12000 : 0);
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // Monitor: compares one queued expectation per cycle.
  always @(negedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, {31'b0, pwm_out}, {31'b0, e});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Driver: queue a waveform starting at count 0 of the current cycle.
  task automatic push_wave(input string tag, input int len, input int tot,
                           input int act, input int dv, input bit hi, input int n);
    for (int j = 0; j < n; j++) begin
      int  k;
      bit  a;
      k = (j / dv) % (len);
      a = (k < act);
      if (tot < 0) a = 1'b0;
      exp_q.push_back(a ? hi : !hi);
      tag_q.push_back(tag);
    end
  endtask

  task automatic push_const(input string tag, input bit v, input int n);
    for (int j = 0; j < n; j++) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic stop();
    wr(4'h0, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int busy_cycles;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out", {31'b0, pwm_out}, 32'h0);
    rd(4'h0, r); chk("R1 ctrl", r, 32'h0);
    rd(4'h4, r); chk("R1 period", r, 32'h0);

    // R2 / R8 idle reload: busy for exactly one cycle
    wr(4'h4, 32'h0003_0001);
    rd(4'h0, r); chk("R8 busy set", r[28], 1'b1);
    @(negedge clk);
    rd(4'h0, r); chk("R8 idle reload", r[28], 1'b0);
    rd(4'h4, r); chk("R2 period readback", r, 32'h0003_0001);

    // R4 continuous, div 1, active high: length 4, active 1
    wr(4'h0, 32'h7F);
    push_wave("R4", 4, 3, 1, 1, 1'b1, 16);
    drain();
    rd(4'h0, r); chk("R2 ctrl readback", r, 32'h7F);

    // R3 enable without gate, gate without enable
    wr(4'h0, 32'h3F);
    push_const("R3 no gate", 1'b0, 6); drain();
    wr(4'h0, 32'h6F);
    push_const("R3 no enable", 1'b0, 6); drain();

    // R7 active low
    stop();
    wr(4'h0, 32'h5F);
    push_wave("R7", 4, 3, 1, 1, 1'b0, 12);
    drain();

    // R5 divide by 12
    stop();
    wr(4'h4, 32'h0002_0001);
    wr(4'h0, 32'h75);
    push_wave("R5 div12", 3, 2, 1, bench_div(5), 1'b1, 72);
    drain();

    // R5 divide by 120
    stop();
    wr(4'h4, 32'h0001_0001);
    wr(4'h0, 32'h70);
    push_wave("R5 div120", 2, 1, 1, bench_div(0), 1'b1, 480);
    drain();

    // R6 reserved codes freeze the counter at count 0
    stop();
    wr(4'h0, 32'h76);
    push_const("R6 code6", 1'b1, 40); drain();
    stop();
    wr(4'h0, 32'h7C);
    push_const("R6 codeC", 1'b1, 40); drain();

    // R10 full and zero duty
    stop();
    wr(4'h4, 32'h0003_0004);
    wr(4'h0, 32'h7F);
    push_const("R10 full", 1'b1, 16); drain();
    stop();
    wr(4'h4, 32'h0003_0000);
    wr(4'h0, 32'h7F);
    push_const("R10 zero", 1'b0, 16); drain();

    // R8 deferred reload while running
    stop();
    wr(4'h4, 32'h0007_0002);
    wr(4'h0, 32'h7F);
    push_wave("R8 old", 8, 7, 2, 1, 1'b1, 3);
    drain();
    wr(4'h4, 32'h0001_0001);
    busy_cycles = 0;
    forever begin
      rd(4'h0, r);
      if (r[28] == 1'b0 || busy_cycles > 20) break;
      busy_cycles++;
      @(negedge clk);
    end
    chk("R8 busy held", (busy_cycles >= 2 && busy_cycles <= 8) ? 32'h1 : 32'h0, 32'h1);
    push_wave("R8 new", 2, 1, 1, 1, 1'b1, 10);
    drain();

    // R9 one-shot: length 4, active 2, then inactive; then retrigger
    stop();
    wr(4'h4, 32'h0003_0002);
    wr(4'h0, 32'h1FF);
    push_wave("R9 shot", 4, 3, 2, 1, 1'b1, 4);
    push_const("R9 after", 1'b0, 8);
    drain();
    rd(4'h0, r); chk("R9 start cleared", r, 32'hFF);
    wr(4'h0, 32'h1FF);
    push_wave("R9 retrigger", 4, 3, 2, 1, 1'b1, 4);
    push_const("R9 after2", 1'b0, 6);
    drain();

    // R11 bypass follows the clock
    wr(4'h0, 32'h200);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #5;
      chk("R11 high", {31'b0, pwm_out}, 32'h1);
      @(negedge clk); #5;
      chk("R11 low", {31'b0, pwm_out}, 32'h0);
    end

    // R3 stopped output low
    stop();
    @(negedge clk); #5;
    chk("R3 stopped", {31'b0, pwm_out}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule